// File: doc/BRIEF.md
# Data Memory Write Mask Classifier

This block sits beside a wide data memory bus and condenses each cycle of bus activity into at most one structured trace event. It watches a request strobe, a write enable, a byte address, the write data with its bit-level write mask, and the read data returned in the same cycle. From these inputs it decides whether the cycle was a full-width read, a full-width write, a write to one aligned 32-bit lane, or a write whose mask has some other shape.

A mask is judged lane by lane. Each 32-bit lane is either fully set, fully clear, or partial. If every lane is set, the cycle is a wide write. If exactly one lane is set and all others are clear, the cycle is a narrow write, and the block works out that lane's exact byte address and extracts its 32 data bits. Any other shape is reported as an error, and the error event carries the raw mask and data. An all-zero mask is also an error.

The event is registered, so it appears one cycle after the bus activity. A single-cycle valid flag goes with a two-bit kind code, an address, data and mask fields.

Top module: `memtrace_classifier`

## Requirements
- R1: A synchronous active-high reset clears evValid, evKind, evAddr, evData and evMask to zero. A request presented during reset produces no event.
- R2: A request sampled at a rising edge produces its event on the outputs right after that edge. evValid is high for exactly that one cycle, and at most one event appears per cycle.
- R3: A read (reqValid=1, reqWrite=0, rdValid=1) yields evKind=0. evAddr is reqAddr with its low log2(DATA_W/8) bits cleared, evData is rdData, and evMask is zero.
- R4: A write whose mask has all DATA_W bits set yields evKind=1. evAddr is the DATA_W-aligned address, evData is the full write data, and evMask is zero.
- R5: A write whose mask fully sets exactly one lane i (lane i is bits LANE_W*i+LANE_W-1 down to LANE_W*i) and clears all other bits yields evKind=2. evAddr is the aligned base plus (LANE_W/8)*i, which is 4*i by default. evData holds that lane's bits in its low LANE_W bits, with zeros above. evMask is zero.
- R6: A write with any other mask yields evKind=3. This covers a partial lane, several set lanes short of all, and an all-zero mask. evAddr is the aligned base, evData is the full write data, and evMask is the raw mask.
- R7: In any cycle where evValid is low, evKind, evAddr, evData and evMask are all zero.
- R8: A read request with rdValid low, or rdValid high without a request, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Bus request present this cycle |
| reqWrite | input | 1 | Request is a write when high, a read when low |
| reqAddr | input | ADDR_W | Byte address of the request |
| wrData | input | DATA_W | Write data |
| wrMask | input | DATA_W | Bit-level write mask |
| rdValid | input | 1 | Read data valid this cycle |
| rdData | input | DATA_W | Read data from the bus |
| evValid | output | 1 | One-cycle event strobe |
| evKind | output | 2 | 0 read, 1 wide write, 2 narrow write, 3 mask error |
| evAddr | output | ADDR_W | Resolved byte address |
| evData | output | DATA_W | Full data, or lane data zero-extended |
| evMask | output | DATA_W | Raw mask on error, else zero |

## Verification
The bench builds the block with DATA_W=64, LANE_W=16 and ADDR_W=16, which gives four lanes. With four lanes, every combination of per-lane mask states (clear, fully set, partial with the cleared bit moving) can be swept, 81 combinations in all. That one sweep covers the wide, narrow and error classifications together with every lane's address offset and data extraction. Reads and non-events are swept across several unaligned addresses so the alignment arithmetic can be checked against values the bench computes itself.

// File: rtl/memtrace_pkg.sv
package memtrace_pkg;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_WIDE   = 2'd1,
    KIND_NARROW = 2'd2,
    KIND_ERR    = 2'd3
  } evKind_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic    fire;
    evKind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/memtrace_ctrl.sv
module memtrace_ctrl
  import memtrace_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int LANE_W = 32,
  localparam int LANES = DATA_W / LANE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] wrMask,
  output ctrlStrobe_t       strobe,
  output logic [LIDX_W-1:0] laneIdx
);

  logic [LANES-1:0] laneFull;
  logic [LANES-1:0] laneEmpty;
  logic             allFull;
  logic             singleLane;

  // Per-lane reduction of the bit mask
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneFull[g]  = &wrMask[g*LANE_W +: LANE_W];
    assign laneEmpty[g] = ~|wrMask[g*LANE_W +: LANE_W];
  end

  assign allFull    = &laneFull;
  assign singleLane = ($countones(laneFull) == 1) && (&(laneFull | laneEmpty));

  // Encode the index of the set lane
  always_comb begin
    laneIdx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneFull[i]) laneIdx = LIDX_W'(i);
    end
  end

  always_comb begin
    strobe.fire = 1'b0;
    strobe.kind = KIND_READ;
    if (reqValid) begin
      if (!reqWrite) begin
        strobe.fire = rdValid;
        strobe.kind = KIND_READ;
      end else begin
        strobe.fire = 1'b1;
        if (allFull)         strobe.kind = KIND_WIDE;
        else if (singleLane) strobe.kind = KIND_NARROW;
        else                 strobe.kind = KIND_ERR;
      end
    end
  end

  // R5
  narrow_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.fire && strobe.kind == KIND_NARROW && LANES > 1) |-> $onehot(laneFull));

  // R6
  err_not_full_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.fire && strobe.kind == KIND_ERR) |-> !(&laneFull));

endmodule

// File: rtl/memtrace_dp.sv
module memtrace_dp
  import memtrace_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int LANE_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / LANE_W,
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [LIDX_W-1:0] laneIdx,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMask,
  input  logic [DATA_W-1:0] rdData,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [ADDR_W-1:0] evAddr,
  output logic [DATA_W-1:0] evData,
  output logic [DATA_W-1:0] evMask
);

  localparam int WIDE_SH = $clog2(DATA_W / 8);
  localparam int LANE_SH = $clog2(LANE_W / 8);
  localparam logic [ADDR_W-1:0] WIDE_LOW = ADDR_W'((64'd1 << WIDE_SH) - 64'd1);

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] laneAddr;
  logic [LANE_W-1:0] laneData;
  logic [ADDR_W-1:0] nAddr;
  logic [DATA_W-1:0] nData;
  logic [DATA_W-1:0] nMask;

  assign baseAddr = reqAddr & ~WIDE_LOW;
  assign laneAddr = baseAddr | (ADDR_W'(laneIdx) << LANE_SH);

  always_comb begin
    laneData = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneIdx == LIDX_W'(i)) laneData = wrData[i*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    nAddr = baseAddr;
    nData = wrData;
    nMask = '0;
    unique case (strobe.kind)
      KIND_READ:   nData = rdData;
      KIND_WIDE:   nData = wrData;
      KIND_NARROW: begin
        nAddr = laneAddr;
        nData = DATA_W'(laneData);
      end
      KIND_ERR:    nMask = wrMask;
      default:     nMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.fire) begin
      evValid <= 1'b0;
      evKind  <= 2'd0;
      evAddr  <= '0;
      evData  <= '0;
      evMask  <= '0;
    end else begin
      evValid <= 1'b1;
      evKind  <= strobe.kind;
      evAddr  <= nAddr;
      evData  <= nData;
      evMask  <= nMask;
    end
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !evValid |-> (evKind == 2'd0 && evAddr == '0 && evData == '0 && evMask == '0));

  // R3
  read_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd0) |-> ((evAddr & WIDE_LOW) == '0 && evMask == '0));

  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd2) |-> ((evData >> LANE_W) == '0));

endmodule

// File: rtl/memtrace_classifier.sv
module memtrace_classifier
  import memtrace_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int LANE_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMask,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [ADDR_W-1:0] evAddr,
  output logic [DATA_W-1:0] evData,
  output logic [DATA_W-1:0] evMask
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  ctrlStrobe_t       strobe;
  logic [LIDX_W-1:0] laneIdx;

  memtrace_ctrl #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .rdValid  (rdValid),
    .wrMask   (wrMask),
    .strobe   (strobe),
    .laneIdx  (laneIdx)
  );

  memtrace_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .laneIdx (laneIdx),
    .reqAddr (reqAddr),
    .wrData  (wrData),
    .wrMask  (wrMask),
    .rdData  (rdData),
    .evValid (evValid),
    .evKind  (evKind),
    .evAddr  (evAddr),
    .evData  (evData),
    .evMask  (evMask)
  );

  // R2
  ev_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    evValid |-> $past(reqValid));

  // R4
  wide_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd1) |-> ((&$past(wrMask)) && evMask == '0));

  // R6
  err_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd3) |-> (evMask == $past(wrMask) && evData == $past(wrData)));

  // R8
  no_read_data_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqWrite && !rdValid) |=> !evValid);

endmodule

// File: tb/memtrace_classifier_test.sv
module memtrace_classifier_test;

  localparam int DW = 64;
  localparam int LW = 16;
  localparam int AW = 16;
  localparam int NL = DW / LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] wrMask = '0;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          evValid;
  logic [1:0]    evKind;
  logic [AW-1:0] evAddr;
  logic [DW-1:0] evData;
  logic [DW-1:0] evMask;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  memtrace_classifier #(.DATA_W(DW), .LANE_W(LW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .wrData(wrData), .wrMask(wrMask), .rdValid(rdValid),
    .rdData(rdData), .evValid(evValid), .evKind(evKind), .evAddr(evAddr),
    .evData(evData), .evMask(evMask)
  );

  task automatic checkEv(input string req, input logic v, input logic [1:0] k,
                         input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [DW-1:0] m);
    checks++;
    if (evValid !== v || evKind !== k || evAddr !== a || evData !== d || evMask !== m) begin
      errors++;
      $display("FAIL %s: actual v=%0b k=%0d a=%h d=%h m=%h expected v=%0b k=%0d a=%h d=%h m=%h",
               req, evValid, evKind, evAddr, evData, evMask, v, k, a, d, m);
    end
  endtask

  // Present one cycle of bus activity; returns at the negedge after its capture edge
  task automatic drive(input logic v, input logic w, input logic rv,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [DW-1:0] m, input logic [DW-1:0] r);
    @(negedge clk);
    reqValid = v; reqWrite = w; rdValid = rv;
    reqAddr = a; wrData = d; wrMask = m; rdData = r;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; rdValid = 1'b0;
  endtask

  function automatic logic [AW-1:0] alignW(input logic [AW-1:0] a);
    return a - (a % AW'(DW / 8));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, m, r;
    logic [AW-1:0] a;
    // R1: request held during reset is dropped
    reqValid = 1'b1; reqWrite = 1'b1; wrMask = '1; wrData = 64'h1234;
    repeat (3) @(negedge clk);
    checkEv("R1 reset", 0, 0, '0, '0, '0);
    rst = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; wrMask = '0; wrData = '0;
    @(negedge clk);
    checkEv("R1 after reset", 0, 0, '0, '0, '0);

    // R3: reads at several addresses
    for (int i = 0; i < 6; i++) begin
      a = AW'(i * 37 + 3);
      r = {$urandom, $urandom};
      drive(1, 0, 1, a, 64'hdead, 64'h0f, r);
      checkEv("R3 read", 1, 0, alignW(a), r, '0);
      @(negedge clk);
      // R2, R7: the event lasts one cycle and clears afterwards
      checkEv("R2 R7 single pulse", 0, 0, '0, '0, '0);
    end

    // R8: no event without read data, or without a request
    drive(1, 0, 0, 16'h0040, '0, '0, 64'h55);
    checkEv("R8 read without data", 0, 0, '0, '0, '0);
    drive(0, 0, 1, 16'h0040, '0, '0, 64'h55);
    checkEv("R8 data without request", 0, 0, '0, '0, '0);
    drive(0, 1, 0, 16'h0040, 64'h77, '1, '0);
    checkEv("R8 write without request", 0, 0, '0, '0, '0);

    // R4 R5 R6: sweep all per-lane states 0=clear 1=full 2=partial
    for (int c = 0; c < 81; c++) begin
      int st[NL];
      int nFull, nPart, lane, t;
      t = c; nFull = 0; nPart = 0; lane = 0; m = '0;
      for (int i = 0; i < NL; i++) begin
        st[i] = t % 3; t = t / 3;
        if (st[i] == 1) begin
          nFull++; lane = i;
          m[i*LW +: LW] = '1;
        end else if (st[i] == 2) begin
          nPart++;
          m[i*LW +: LW] = ~(16'(1) << ((c + i) % LW));
        end
      end
      d = {$urandom, $urandom};
      a = AW'(c * 13 + 5);
      drive(1, 1, 0, a, d, m, 64'hffff);
      if (nFull == NL)
        checkEv("R4 wide write", 1, 1, alignW(a), d, '0);
      else if (nFull == 1 && nPart == 0)
        checkEv("R5 narrow write", 1, 2, alignW(a) + AW'(lane * (LW / 8)),
                (d >> (lane * LW)) & 64'hffff, '0);
      else
        checkEv("R6 mask error", 1, 3, alignW(a), d, m);
    end

    // R6: a mask spanning two lanes at an odd offset
    m = 64'h0000_ffff_ffff_0000 >> 4;
    drive(1, 1, 0, 16'h0123, 64'hcafe, m, '0);
    checkEv("R6 straddling mask", 1, 3, alignW(16'h0123), 64'hcafe, m);

    // R2: back-to-back requests produce back-to-back events
    @(negedge clk);
    reqValid = 1; reqWrite = 1; rdValid = 0; reqAddr = 16'h0010; wrData = 64'h1111; wrMask = '1;
    @(negedge clk);
    checkEv("R2 back-to-back first", 1, 1, 16'h0010, 64'h1111, '0);
    reqWrite = 0; rdValid = 1; rdData = 64'h2222; reqAddr = 16'h0019;
    @(negedge clk);
    checkEv("R2 back-to-back second", 1, 0, 16'h0018, 64'h2222, '0);
    reqValid = 0; rdValid = 0;
    @(negedge clk);
    checkEv("R7 idle after burst", 0, 0, '0, '0, '0);

    // R1: reset mid-stream clears a pending event
    reqValid = 1; reqWrite = 1; wrMask = '1; wrData = 64'h9;
    rst = 1;
    @(negedge clk);
    checkEv("R1 reset clears", 0, 0, '0, '0, '0);
    rst = 0; reqValid = 0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule